// File: doc/BRIEF.md
# Early/Late Delay-Tap Phase Aligner

This block keeps a frequency-multiplied clock in phase with the slower reference it was derived from. It never measures how large the phase error is. Two sampling latches beside the block compare the START edge, which passes through an adjustable delay line, with the STOP edge, which passes through a fixed delay T. T must be longer than one period of the multiplied clock. The latches report only which edge came first. The block runs on the STOP-domain control clock, so each of its cycles is one STOP period. It passes the two latch bits through a synchronizer and turns them into at most one tap step per cycle on the delay line.

The tap setting is kept in a saturating counter. The counter starts at mid-range and stops at either end instead of wrapping. Each step is announced on a single-cycle increment or decrement strobe, and the new tap value is presented at the same time. A lock flag rises once a set number of consecutive cycles has passed with no step. The control rule is the same for every multiplication ratio from 2 to 32. With a tap quantum of about 75 ps, the loop settles into a dither of a few quanta around the aligned point.

Top module: `bba_phase_align`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, the tap output equals NUM_TAPS/2, both strobes are 0 and the lock flag is 0.
- R2: A synchronized latch pair with lat_a=1 and lat_b=0 raises the tap by exactly one and pulses tap_inc for one cycle, provided the tap is below NUM_TAPS-1.
- R3: A synchronized latch pair with lat_a=1 and lat_b=1 lowers the tap by exactly one and pulses tap_dec for one cycle, provided the tap is above 0.
- R4: A synchronized latch pair with lat_a=0, whatever lat_b is, leaves the tap unchanged and raises neither strobe.
- R5: A latch pair that is present at rising edge k changes the tap output at rising edge k+2 at the earliest, after two synchronizer stages and one update register. The tap is unchanged after edges k and k+1.
- R6: At tap NUM_TAPS-1, a raise request leaves the tap at NUM_TAPS-1 and raises no tap_inc.
- R7: At tap 0, a lower request leaves the tap at 0 and raises no tap_dec.
- R8: tap_inc and tap_dec are never high in the same cycle, and the tap moves by at most one per cycle.
- R9: tap_inc is high exactly in the cycles where the tap has just risen by one, and tap_dec exactly in the cycles where it has just fallen by one.
- R10: locked is high once LOCK_CYCLES consecutive cycles have passed with neither strobe high. It is low in the cycle after any strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | STOP-domain control clock, one cycle per STOP period |
| rst | input | 1 | Synchronous active-high reset |
| lat_a | input | 1 | Asynchronous early/late latch bit A |
| lat_b | input | 1 | Asynchronous early/late latch bit B |
| tap_o | output | $clog2(NUM_TAPS) | Current delay-line tap setting on the START path |
| tap_inc | output | 1 | One-cycle strobe: the tap has just been raised by one |
| tap_dec | output | 1 | One-cycle strobe: the tap has just been lowered by one |
| locked | output | 1 | No tap step for LOCK_CYCLES consecutive cycles |

## Verification
The bench builds the block with NUM_TAPS=8 and LOCK_CYCLES=4. With these values, both saturation rails can be reached from mid-range within a few cycles of holding a raise or lower request, so each latch combination is held long enough to run the tap to the rail and keep it there. A pseudo-random stream of latch pairs with varying hold lengths then covers every transition between combinations at every tap value. The short lock window lets the lock flag be seen rising and dropping many times.

// File: rtl/bba_pkg.sv
package bba_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic samp_a;
        logic samp_b;
    } probe_t;

    // A set with B clear: START is early, so lengthen its path.
    // Both set: START is late, so shorten it. Otherwise no action.
    function automatic step_e decode_step(probe_t p);
        step_e s;
        if (p.samp_a && !p.samp_b)
            s = STEP_UP;
        else if (p.samp_a && p.samp_b)
            s = STEP_DOWN;
        else
            s = STEP_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/bba_sync.sv
module bba_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bba_tapctl.sv
module bba_tapctl
    import bba_pkg::*;
#(
    parameter int NUM_TAPS = 32,
    localparam int TAP_W   = $clog2(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    output logic [TAP_W-1:0] tap,
    output logic             inc,
    output logic             dec
);
    localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(NUM_TAPS - 1);
    localparam logic [TAP_W-1:0] TAP_MID = TAP_W'(NUM_TAPS / 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            tap <= TAP_MID;
            inc <= 1'b0;
            dec <= 1'b0;
        end else begin
            inc <= 1'b0;
            dec <= 1'b0;
            case (step)
                STEP_UP: if (tap != TAP_MAX) begin
                    tap <= tap + TAP_W'(1);
                    inc <= 1'b1;
                end
                STEP_DOWN: if (tap != '0) begin
                    tap <= tap - TAP_W'(1);
                    dec <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bba_lock.sv
module bba_lock #(
    parameter int LOCK_CYCLES = 16,
    localparam int CNT_W      = $clog2(LOCK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic adj,
    output logic locked
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_CYCLES);
    logic [CNT_W-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst)                 quiet <= '0;
        else if (adj)            quiet <= '0;
        else if (quiet != CNT_TOP) quiet <= quiet + CNT_W'(1);
    end

    assign locked = (quiet == CNT_TOP);
endmodule

// File: rtl/bba_phase_align.sv
module bba_phase_align
    import bba_pkg::*;
#(
    parameter int NUM_TAPS    = 32,
    parameter int LOCK_CYCLES = 16,
    parameter int SYNC_STAGES = 2,
    localparam int TAP_W      = $clog2(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lat_a,
    input  logic             lat_b,
    output logic [TAP_W-1:0] tap_o,
    output logic             tap_inc,
    output logic             tap_dec,
    output logic             locked
);
    probe_t raw_pair;
    probe_t sync_pair;
    logic [1:0] sync_q;
    step_e step;

    assign raw_pair = '{samp_a: lat_a, samp_b: lat_b};

    bba_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pair),
        .q   (sync_q)
    );

    assign sync_pair = probe_t'(sync_q);
    assign step      = decode_step(sync_pair);

    bba_tapctl #(.NUM_TAPS(NUM_TAPS)) u_tap (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .tap  (tap_o),
        .inc  (tap_inc),
        .dec  (tap_dec)
    );

    bba_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .adj    (tap_inc | tap_dec),
        .locked (locked)
    );
endmodule

// File: rtl/bba_phase_align_chk.sv
module bba_phase_align_chk #(
    parameter int NUM_TAPS = 32,
    localparam int TAP_W   = $clog2(NUM_TAPS)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       sync_q,
    input logic [TAP_W-1:0] tap_o,
    input logic             tap_inc,
    input logic             tap_dec,
    input logic             locked
);
    localparam logic [TAP_W-1:0] TMAX = TAP_W'(NUM_TAPS - 1);

    p_raise_r2: assert property (@(posedge clk) disable iff (rst)
        (sync_q == 2'b10 && tap_o != TMAX) |=> (tap_o == $past(tap_o) + TAP_W'(1)) && tap_inc);

    p_lower_r3: assert property (@(posedge clk) disable iff (rst)
        (sync_q == 2'b11 && tap_o != '0) |=> (tap_o == $past(tap_o) - TAP_W'(1)) && tap_dec);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !sync_q[1] |=> $stable(tap_o) && !tap_inc && !tap_dec);

    p_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
        (sync_q == 2'b10 && tap_o == TMAX) |=> tap_o == TMAX && !tap_inc);

    p_floor_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_q == 2'b11 && tap_o == '0) |=> tap_o == '0 && !tap_dec);

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(tap_inc && tap_dec));

    p_lock_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (tap_inc || tap_dec) |=> !locked);
endmodule

bind bba_phase_align bba_phase_align_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sync_q  (sync_q),
    .tap_o   (tap_o),
    .tap_inc (tap_inc),
    .tap_dec (tap_dec),
    .locked  (locked)
);

// File: tb/bba_phase_align_tb.sv
`timescale 1ns/1ps
module bba_phase_align_tb;
    localparam int NT    = 8;
    localparam int LOCK  = 4;
    localparam int TW    = $clog2(NT);
    localparam int TMID  = NT / 2;
    localparam int TMAX  = NT - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a = 1'b0, b = 1'b0;
    logic [TW-1:0] tap_o;
    logic tap_inc, tap_dec, locked;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit auto_on = 0;
    bit rst_seen = 1;

    always #2.5 clk = ~clk;

    bba_phase_align #(.NUM_TAPS(NT), .LOCK_CYCLES(LOCK)) u_dut (
        .clk(clk), .rst(rst), .lat_a(a), .lat_b(b),
        .tap_o(tap_o), .tap_inc(tap_inc), .tap_dec(tap_dec), .locked(locked)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Expected behaviour, built from the requirements
    logic [1:0] m_s1, m_s2;
    int m_tap, m_cnt;
    bit m_inc, m_dec;
    string m_tag;

    always @(posedge clk) begin
        rst_seen <= rst;
        if (rst) begin
            m_s1 <= 2'b00; m_s2 <= 2'b00;
            m_tap <= TMID; m_inc <= 0; m_dec <= 0; m_cnt <= 0; m_tag <= "R1";
        end else begin
            m_s1 <= {a, b};
            m_s2 <= m_s1;
            m_inc <= 0; m_dec <= 0;
            if (m_s2 == 2'b10) begin
                if (m_tap == TMAX) m_tag <= "R6";
                else begin m_tap <= m_tap + 1; m_inc <= 1; m_tag <= "R2"; end
            end else if (m_s2 == 2'b11) begin
                if (m_tap == 0) m_tag <= "R7";
                else begin m_tap <= m_tap - 1; m_dec <= 1; m_tag <= "R3"; end
            end else m_tag <= "R4";
            if (m_inc || m_dec) m_cnt <= 0;
            else if (m_cnt < LOCK) m_cnt <= m_cnt + 1;
        end
    end

    int prev_tap = TMID;
    always @(negedge clk) begin
        if (auto_on && !rst_seen) begin
            chk(int'(tap_o) == m_tap, m_tag, "tap", int'(tap_o), m_tap);
            chk(tap_inc == m_inc, "R9", "tap_inc", int'(tap_inc), int'(m_inc));
            chk(tap_dec == m_dec, "R9", "tap_dec", int'(tap_dec), int'(m_dec));
            chk(!(tap_inc && tap_dec), "R8", "inc&dec", int'(tap_inc && tap_dec), 0);
            chk((int'(tap_o) - prev_tap <= 1) && (prev_tap - int'(tap_o) <= 1),
                "R8", "tap jump", int'(tap_o), prev_tap);
            chk(locked == (m_cnt >= LOCK), "R10", "locked", int'(locked), int'(m_cnt >= LOCK));
        end
        prev_tap = int'(tap_o);
    end

    task automatic check_reset_state();
        chk(int'(tap_o) == TMID, "R1", "reset tap", int'(tap_o), TMID);
        chk(!tap_inc && !tap_dec, "R1", "reset strobes", int'({tap_inc, tap_dec}), 0);
        chk(!locked, "R1", "reset lock", int'(locked), 0);
    endtask

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        @(negedge clk);
        check_reset_state();
        // R5: latency from latch input to tap output
        a = 1'b1; b = 1'b0;
        @(negedge clk);
        a = 1'b0;
        chk(int'(tap_o) == TMID, "R5", "tap after edge k", int'(tap_o), TMID);
        @(negedge clk);
        chk(int'(tap_o) == TMID, "R5", "tap after edge k+1", int'(tap_o), TMID);
        @(negedge clk);
        chk(int'(tap_o) == TMID + 1, "R5", "tap after edge k+2", int'(tap_o), TMID + 1);
        auto_on = 1;
        // Hold each latch combination long enough to reach a rail
        for (int p = 0; p < 4; p++) begin
            {a, b} = 2'(p);
            repeat (NT + LOCK + 4) @(negedge clk);
        end
        {a, b} = 2'b10;
        repeat (NT + 4) @(negedge clk);
        {a, b} = 2'b11;
        repeat (2 * NT + 4) @(negedge clk);
        // Pseudo-random latch pairs with varying hold lengths
        lfsr = 8'hA5;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            {a, b} = lfsr[1:0];
            repeat (1 + int'(lfsr[4:2])) @(negedge clk);
        end
        // Reset in mid-run
        {a, b} = 2'b00;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        repeat (LOCK + 3) @(negedge clk);
        chk(locked == 1'b1, "R10", "lock after quiet", int'(locked), 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule